// File: doc/BRIEF.md
# Address Translation and Access Protection Unit

This unit sits between an access requester and the cache. It turns a virtual address into a physical address by looking up a small fully associative translation buffer. Each buffer entry is tagged with an address-space identifier as well as the virtual page number, so translations for several processes can stay resident together. No invalidation is needed when the running process changes.

On a hit, the entry's permission bits are checked against the kind of access and the privilege mode. The unit then returns either the physical address (physical page number joined to the 12-bit page offset) or a protection fault. On a miss, the unit asks an external page-table walker for the translation and waits for its reply. A resident reply is written into the buffer, and the same access is looked up again. A not-resident reply ends the access with a page fault. Two flush inputs clear either every entry or only the entries of one address space.

Top module: `xlate_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `walk_req_valid` are 0, and every buffer entry is invalid, so the first access to any page misses.
- R2: A request accepted at clock edge k that hits returns `rsp_valid`=1 for one cycle after edge k+1. In that response, `rsp_kind`=0 (ok) and `rsp_pa` = {physical page number, `req_va[11:0]`}.
- R3: The permission field is {user bit 3, execute bit 2, write bit 1, read bit 0}. The access is denied with `rsp_kind`=1 (protection fault) in any of these cases: a user-mode access to a page with user=0; a write to a page with write=0; an execute to a page with execute=0; a plain read to a page with read=0. `req_write` and `req_exec` are never both set. Supervisor mode may access pages with user=1.
- R4: A fault response (`rsp_kind` 1 or 2) carries `rsp_pa`=0.
- R5: On a miss, `walk_req_valid` rises after edge k+1 with `walk_req_vpn`=`req_va[31:12]` and the request's identifier. It stays high with stable fields until a cycle with `walk_rsp_valid`=1.
- R6: A walker reply with `walk_rsp_present`=0 yields `rsp_kind`=2 (page fault) in the cycle after the reply edge. Nothing is written into the buffer, so a repeat access misses again.
- R7: A walker reply with `walk_rsp_present`=1 is written into the buffer and the access is replayed. The response, with the permission check applied, appears one cycle later than for a not-present reply.
- R8: The same virtual page under different identifiers occupies separate entries. Each hits with its own translation.
- R9: Refills replace entries in round-robin order. Once the buffer is full, the next refill evicts the oldest fill.
- R10: A one-cycle `flush_all` pulse invalidates every entry.
- R11: A one-cycle `flush_asid` pulse invalidates only the entries whose identifier equals `flush_asid_id`.
- R12: Exactly one response is produced for each accepted request. `req_ready` is 0 from acceptance until the cycle of that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_va | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space identifier of the access |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access made in user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_kind | output | 2 | 0 ok, 1 protection fault, 2 page fault |
| rsp_pa | output | 32 | Physical address, zero on a fault |
| walk_req_valid | output | 1 | Translation wanted from the walker |
| walk_req_vpn | output | 20 | Virtual page to walk |
| walk_req_asid | output | 8 | Identifier for the walk |
| walk_rsp_valid | input | 1 | Walker reply strobe |
| walk_rsp_present | input | 1 | Page resident |
| walk_rsp_ppn | input | 20 | Physical page number from the walker |
| walk_rsp_perm | input | 4 | Permission bits from the walker |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid | input | 1 | Invalidate entries of one identifier |
| flush_asid_id | input | 8 | Identifier to invalidate |

## Verification
Counted from the acceptance edge, a hit response is due two edges later, and a walk request appears on that same edge instead. A page fault response is due one edge after the walker reply, and a replayed response two edges after it. The bench drives and samples on falling edges and steps exactly those counts of half-period-offset samples before reading `rsp_valid`, `rsp_kind` and `rsp_pa`. It then confirms that the strobe has dropped on the next sample. Whether an access should miss comes from a bench-side record of resident pages and the round-robin fill order. Expected addresses and permissions come from arithmetic functions of the page number and identifier.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    RSP_OK   = 2'd0,
    RSP_PROT = 2'd1,
    RSP_PGF  = 2'd2
  } rsp_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WALK = 2'd2
  } seq_state_e;

  localparam int PERM_W = 4;
  localparam int PB_RD  = 0;
  localparam int PB_WR  = 1;
  localparam int PB_EX  = 2;
  localparam int PB_USR = 3;
endpackage

// File: rtl/xlate_perm.sv
module xlate_perm
  import xlate_pkg::*;
(
  input  logic [PERM_W-1:0] perm,
  input  logic              acc_wr,
  input  logic              acc_ex,
  input  logic              acc_user,
  output logic              allowed
);
  logic deny_user, deny_wr, deny_ex, deny_rd;

  always_comb begin
    deny_user = acc_user && !perm[PB_USR];
    deny_wr   = acc_wr && !perm[PB_WR];
    deny_ex   = acc_ex && !perm[PB_EX];
    deny_rd   = !acc_wr && !acc_ex && !perm[PB_RD];
    allowed   = !(deny_user || deny_wr || deny_ex || deny_rd);
  end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush_all,
  input  logic              flush_asid,
  input  logic [ASID_W-1:0] flush_asid_id
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [PERM_W-1:0]  perm_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q;
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] asid_sel;
  logic [IDX_W-1:0]   hit_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g]    = vld_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
    assign asid_sel[g] = (asid_q[g] == flush_asid_id);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign lk_hit  = |match;
  assign lk_ppn  = ppn_q[hit_idx];
  assign lk_perm = perm_q[hit_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_all || (flush_asid && asid_sel[i])) vld_q[i] <= 1'b0;
      end
      if (fill_en) begin
        vld_q[rr_q] <= 1'b1;
        rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      vpn_q[rr_q]  <= fill_vpn;
      asid_q[rr_q] <= fill_asid;
      ppn_q[rr_q]  <= fill_ppn;
      perm_q[rr_q] <= fill_perm;
    end
  end

  assert_single_match_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  assert_flush_all_R10: assert property (@(posedge clk) disable iff (rst)
    (flush_all && !fill_en) |=> (vld_q == '0));

  assert_flush_asid_R11: assert property (@(posedge clk) disable iff (rst)
    (flush_asid && !fill_en) |=> ((vld_q & $past(asid_sel)) == '0));
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  input  logic              req_exec,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic [1:0]        rsp_kind,
  output logic [PPN_W+OFF_W-1:0] rsp_pa,
  output logic              walk_req_valid,
  output logic [VA_W-OFF_W-1:0] walk_req_vpn,
  output logic [ASID_W-1:0] walk_req_asid,
  input  logic              walk_rsp_valid,
  input  logic              walk_rsp_present,
  input  logic [PPN_W-1:0]  walk_rsp_ppn,
  input  logic [3:0]        walk_rsp_perm,
  input  logic              flush_all,
  input  logic              flush_asid,
  input  logic [ASID_W-1:0] flush_asid_id
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  seq_state_e        st_q;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic              wr_q, ex_q, us_q;
  logic              rsp_v_q;
  rsp_kind_e         rsp_k_q;
  logic [PA_W-1:0]   rsp_pa_q;

  logic              hit;
  logic [PPN_W-1:0]  hit_ppn;
  logic [PERM_W-1:0] hit_perm;
  logic              ok;
  logic              fill_en;

  assign fill_en = (st_q == ST_WALK) && walk_rsp_valid && walk_rsp_present;

  xlate_tlb #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)
  ) u_tlb (
    .clk          (clk),
    .rst          (rst),
    .lk_vpn       (va_q[VA_W-1:OFF_W]),
    .lk_asid      (asid_q),
    .lk_hit       (hit),
    .lk_ppn       (hit_ppn),
    .lk_perm      (hit_perm),
    .fill_en      (fill_en),
    .fill_vpn     (va_q[VA_W-1:OFF_W]),
    .fill_asid    (asid_q),
    .fill_ppn     (walk_rsp_ppn),
    .fill_perm    (walk_rsp_perm),
    .flush_all    (flush_all),
    .flush_asid   (flush_asid),
    .flush_asid_id(flush_asid_id)
  );

  xlate_perm u_perm (
    .perm    (hit_perm),
    .acc_wr  (wr_q),
    .acc_ex  (ex_q),
    .acc_user(us_q),
    .allowed (ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      va_q     <= '0;
      asid_q   <= '0;
      wr_q     <= 1'b0;
      ex_q     <= 1'b0;
      us_q     <= 1'b0;
      rsp_v_q  <= 1'b0;
      rsp_k_q  <= RSP_OK;
      rsp_pa_q <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            asid_q <= req_asid;
            wr_q   <= req_write;
            ex_q   <= req_exec;
            us_q   <= req_user;
            st_q   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            rsp_v_q <= 1'b1;
            st_q    <= ST_IDLE;
            if (ok) begin
              rsp_k_q  <= RSP_OK;
              rsp_pa_q <= {hit_ppn, va_q[OFF_W-1:0]};
            end else begin
              rsp_k_q  <= RSP_PROT;
              rsp_pa_q <= '0;
            end
          end else begin
            st_q <= ST_WALK;
          end
        end
        ST_WALK: begin
          if (walk_rsp_valid) begin
            if (walk_rsp_present) begin
              st_q <= ST_LOOK;
            end else begin
              rsp_v_q  <= 1'b1;
              rsp_k_q  <= RSP_PGF;
              rsp_pa_q <= '0;
              st_q     <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign rsp_valid      = rsp_v_q;
  assign rsp_kind       = rsp_k_q;
  assign rsp_pa         = rsp_pa_q;
  assign walk_req_valid = (st_q == ST_WALK);
  assign walk_req_vpn   = va_q[VA_W-1:OFF_W];
  assign walk_req_asid  = asid_q;

  assert_rsp_single_R12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_busy_walk_R12: assert property (@(posedge clk) disable iff (rst)
    walk_req_valid |-> !req_ready);

  assert_fault_nopa_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind != 2'd0) |-> (rsp_pa == '0));

  assert_walk_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (walk_req_valid && !walk_rsp_valid) |=>
      (walk_req_valid && $stable(walk_req_vpn) && $stable(walk_req_asid)));

  assert_pgf_R6: assert property (@(posedge clk) disable iff (rst)
    (walk_req_valid && walk_rsp_valid && !walk_rsp_present) |=>
      (rsp_valid && rsp_kind == 2'd2));

  assert_replay_R7: assert property (@(posedge clk) disable iff (rst)
    (walk_req_valid && walk_rsp_valid && walk_rsp_present) |=>
      (!rsp_valid && !walk_req_valid && !req_ready));
endmodule

// File: tb/tb_xlate_ctrl.sv
module tb_xlate_ctrl;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready;
  logic [31:0] req_va;
  logic [7:0]  req_asid;
  logic        req_write, req_exec, req_user;
  logic        rsp_valid;
  logic [1:0]  rsp_kind;
  logic [31:0] rsp_pa;
  logic        walk_req_valid;
  logic [19:0] walk_req_vpn;
  logic [7:0]  walk_req_asid;
  logic        walk_rsp_valid, walk_rsp_present;
  logic [19:0] walk_rsp_ppn;
  logic [3:0]  walk_rsp_perm;
  logic        flush_all, flush_asid;
  logic [7:0]  flush_asid_id;

  int total = 0;
  int bad   = 0;

  logic [19:0] m_vpn  [8];
  logic [7:0]  m_asid [8];
  logic        m_val  [8];
  int          m_rr;

  always #4 clk = ~clk;

  xlate_ctrl dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_asid(req_asid), .req_write(req_write), .req_exec(req_exec),
    .req_user(req_user), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_pa(rsp_pa), .walk_req_valid(walk_req_valid),
    .walk_req_vpn(walk_req_vpn), .walk_req_asid(walk_req_asid),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_present(walk_rsp_present),
    .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_perm(walk_rsp_perm),
    .flush_all(flush_all), .flush_asid(flush_asid),
    .flush_asid_id(flush_asid_id)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] ppn_of(input logic [19:0] v, input logic [7:0] a);
    return (v * 20'd13) ^ {a, 12'h5C3};
  endfunction

  function automatic logic [3:0] perm_of(input logic [19:0] v, input logic [7:0] a);
    return 4'((32'(v) * 7 + 32'(a) * 3) & 32'hF);
  endfunction

  function automatic bit denied(input logic [3:0] p, input bit wr, input bit ex, input bit us);
    return (us && !p[3]) || (wr && !p[1]) || (ex && !p[2]) || (!wr && !ex && !p[0]);
  endfunction

  function automatic bit m_hit(input logic [19:0] v, input logic [7:0] a);
    for (int i = 0; i < 8; i++)
      if (m_val[i] && m_vpn[i] == v && m_asid[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic access(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [7:0] asid, input bit wr, input bit ex,
                        input bit us, input bit present, input int wdly,
                        input string tag);
    bit exp_miss;
    logic [3:0] p;
    logic [1:0] ek;
    logic [31:0] epa;
    exp_miss = !m_hit(vpn, asid);
    p = perm_of(vpn, asid);
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", {tag, " ready before request"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_va = {vpn, off}; req_asid = asid;
    req_write = wr; req_exec = ex; req_user = us;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12", {tag, " busy after accept"}, 64'(req_ready), 64'd0);
    @(negedge clk);
    chk(walk_req_valid == exp_miss, "R5", {tag, " miss detect"}, 64'(walk_req_valid), 64'(exp_miss));
    if (walk_req_valid) begin
      chk(walk_req_vpn == vpn && walk_req_asid == asid, "R5", {tag, " walk fields"},
          64'({walk_req_asid, walk_req_vpn}), 64'({asid, vpn}));
      for (int d = 0; d < wdly; d++) begin
        @(negedge clk);
        chk(walk_req_valid == 1'b1 && rsp_valid == 1'b0, "R5", {tag, " walk held"},
            64'(walk_req_valid), 64'd1);
      end
      walk_rsp_valid = 1'b1; walk_rsp_present = present;
      walk_rsp_ppn = ppn_of(vpn, asid); walk_rsp_perm = p;
      @(negedge clk);
      walk_rsp_valid = 1'b0;
      if (!present) begin
        chk(rsp_valid == 1'b1 && rsp_kind == 2'd2, "R6", {tag, " page fault"},
            64'({rsp_valid, rsp_kind}), 64'({1'b1, 2'd2}));
        chk(rsp_pa == 32'd0, "R4", {tag, " pgf pa"}, 64'(rsp_pa), 64'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R12", {tag, " single rsp"}, 64'(rsp_valid), 64'd0);
        return;
      end
      chk(rsp_valid == 1'b0 && walk_req_valid == 1'b0, "R7", {tag, " replay gap"},
          64'({rsp_valid, walk_req_valid}), 64'd0);
      m_vpn[m_rr] = vpn; m_asid[m_rr] = asid; m_val[m_rr] = 1'b1;
      m_rr = (m_rr + 1) % 8;
      @(negedge clk);
    end
    if (denied(p, wr, ex, us)) begin ek = 2'd1; epa = 32'd0; end
    else begin ek = 2'd0; epa = {ppn_of(vpn, asid), off}; end
    chk(rsp_valid == 1'b1 && rsp_kind == ek, exp_miss ? "R7" : "R3", {tag, " kind"},
        64'({rsp_valid, rsp_kind}), 64'({1'b1, ek}));
    chk(rsp_pa == epa, (ek == 2'd0) ? "R2" : "R4", {tag, " pa"}, 64'(rsp_pa), 64'(epa));
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", {tag, " single rsp"}, 64'(rsp_valid), 64'd0);
  endtask

  task automatic do_flush(input bit all, input logic [7:0] id);
    @(negedge clk);
    flush_all = all; flush_asid = !all; flush_asid_id = id;
    @(negedge clk);
    flush_all = 1'b0; flush_asid = 1'b0;
    for (int i = 0; i < 8; i++)
      if (all || m_asid[i] == id) m_val[i] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_asid = '0;
    req_write = 1'b0; req_exec = 1'b0; req_user = 1'b0;
    walk_rsp_valid = 1'b0; walk_rsp_present = 1'b0; walk_rsp_ppn = '0; walk_rsp_perm = '0;
    flush_all = 1'b0; flush_asid = 1'b0; flush_asid_id = '0;
    for (int i = 0; i < 8; i++) begin m_val[i] = 1'b0; m_vpn[i] = '0; m_asid[i] = '0; end
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(req_ready == 1'b1 && rsp_valid == 1'b0 && walk_req_valid == 1'b0, "R1", "reset outputs",
        64'({req_ready, rsp_valid, walk_req_valid}), 64'b100);

    // R1 R5 R7: fill eight pages of identifier 3, walker delay varies
    for (int v = 0; v < 8; v++)
      access(20'(v), 12'(v * 37 + 5), 8'd3, 1'b0, 1'b0, 1'b0, 1'b1, v % 3, "fill");

    // R2 R3: exhaustive access-type sweep on resident pages
    for (int v = 0; v < 8; v++)
      for (int m = 0; m < 3; m++)
        for (int u = 0; u < 2; u++)
          access(20'(v), 12'(v * 291 + m * 17 + u), 8'd3, m == 1, m == 2, u == 1,
                 1'b1, 0, "perm");

    // R8 R9: same page, other identifier, evicts oldest fill (page 0 of id 3)
    access(20'd2, 12'h0AB, 8'd5, 1'b0, 1'b0, 1'b0, 1'b1, 1, "asid5");
    access(20'd2, 12'h0AC, 8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 0, "coexist");
    access(20'd2, 12'h0AD, 8'd5, 1'b1, 1'b0, 1'b1, 1'b1, 0, "asid5 hit");
    access(20'd0, 12'h001, 8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 0, "evicted R9");
    access(20'd1, 12'h002, 8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 0, "evicted2 R9");

    // R6: not-present page, then again (no fill happened)
    access(20'h123, 12'h456, 8'd7, 1'b0, 1'b0, 1'b0, 1'b0, 2, "pgf");
    access(20'h123, 12'h457, 8'd7, 1'b0, 1'b0, 1'b0, 1'b0, 0, "pgf again");

    // R11: identifier flush leaves other identifier resident
    do_flush(1'b0, 8'd3);
    access(20'd2, 12'h111, 8'd5, 1'b0, 1'b0, 1'b0, 1'b1, 0, "survivor R11");
    access(20'd3, 12'h112, 8'd3, 1'b0, 1'b0, 1'b0, 1'b1, 0, "flushed R11");

    // R10: global flush
    do_flush(1'b1, 8'd0);
    access(20'd2, 12'h221, 8'd5, 1'b0, 1'b0, 1'b0, 1'b1, 0, "gflush R10");
    access(20'd3, 12'h222, 8'd3, 1'b0, 1'b1, 1'b1, 1'b1, 0, "gflush2 R10");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule